// File: doc/BRIEF.md
# Module Clock and Reset State Controller

This block keeps a set of peripheral modules in one of three operating states: disabled (clock stopped, reset held), synchronous reset (clock running, reset held) or enabled (clock running, reset released). Software stages a requested state for each module in a per-module control register. Nothing moves until software writes a start command. The controller then applies every staged change in one transition. It raises a busy flag while it works and updates each module's status word and its clock-enable and reset outputs as each change lands.

Modules are changed one at a time in ascending index order. Each change takes a fixed number of cycles. Modules that already sit in their requested state are skipped. Only the always-on modules, those with an index below `AON_CNT`, take part in a transition. Modules at or above that index belong to a separately powered group and keep their reset state. Selected modules also carry an extra control flag that the controller stores and returns on read. Register access is a plain single-cycle write strobe with a combinational read port.

Top module: `modctl`

## Requirements
- R1: After reset every status word reads 0 (disabled), every staged NEXT field reads 0, the busy flag reads 0, every `mod_clk_en` bit is 0 and every `mod_rst_n` bit is 0.
- R2: Writing a control register (address 0x10+i, NEXT field in bits [1:0]) only stages a request. Status words and module outputs do not change until a start command is issued.
- R3: A write to the command register (address 0x00) with bit 0 set, while not busy, sets the busy flag (address 0x01, bit 0) from the next cycle on. It stays set for exactly k*STEP_CYCLES+1 cycles, where k is the number of always-on modules whose NEXT differs from their status. A command write with bit 0 clear starts nothing.
- R4: Changing modules are handled in ascending index order. The j-th changing module (j from 1) shows its new status j*STEP_CYCLES cycles after the first busy cycle, and later modules still show their old status at that point.
- R5: When busy clears, each always-on module's status word (address 0x20+i, bits [1:0]) equals the NEXT value captured when the transition started.
- R6: Modules whose NEXT equals their status are skipped. If no always-on module differs, busy is high for one cycle only.
- R7: A start command written while busy is ignored. It neither lengthens the running transition nor starts another one.
- R8: Control writes made while busy are staged for the next transition and do not change the targets of the running one.
- R9: Bit 9 of a control register is stored and read back for modules whose bit in EXTRA_MASK is set (modules 0 and 2 by default). For all other modules it reads 0.
- R10: Modules with index at or above AON_CNT (4 and 5 by default) never leave the disabled state, whatever their NEXT field holds.
- R11: `mod_clk_en[i]` is 1 exactly when module i is in state 1 or 3. `mod_rst_n[i]` is 1 only in state 3.
- R12: A write of the reserved code 2 to a NEXT field is rejected, so the field keeps its previous value. No status word ever holds 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| mod_clk_en | output | 6 (N_MOD) | Per-module clock enable |
| mod_rst_n | output | 6 (N_MOD) | Per-module active-low reset |

## Verification
A wrong pending mask or a wrong step counter shows up as a busy window of the wrong length. That error is visible in the cycle the flag should drop. It is at most STEP_CYCLES cycles off per module. A wrong order or a wrong captured target shows up in the status words and the module outputs at the exact step edge where a module should land. The bench samples those words on the cycle before, on and after that edge. A sweep over every legal combination of requested states for the always-on modules checks the final status and the outputs against an arithmetic model after each transition. It also checks the staged state before each start command.

// File: rtl/modctl_pkg.sv
package modctl_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_SRST = 2'd1,
    ST_RSV  = 2'd2,
    ST_ON   = 2'd3
  } mstate_e;

  localparam int          AW         = 8;
  localparam logic [AW-1:0] ADR_CMD  = 8'h00;
  localparam logic [AW-1:0] ADR_BUSY = 8'h01;
  localparam logic [AW-1:0] ADR_CTRL = 8'h10;
  localparam logic [AW-1:0] ADR_STAT = 8'h20;
  localparam int          EXTRA_BIT  = 9;
endpackage

// File: rtl/modctl_regs.sv
module modctl_regs
  import modctl_pkg::*;
#(
  parameter int N_MOD = 6,
  parameter int DW    = 32,
  parameter logic [N_MOD-1:0] EXTRA_MASK = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      wdata,
  input  logic               busy,
  input  logic [2*N_MOD-1:0] stat_flat,
  output logic [2*N_MOD-1:0] next_flat,
  output logic               go_fire,
  output logic [DW-1:0]      rdata
);
  logic [N_MOD-1:0][1:0] nxt_q, nxt_d;
  logic [N_MOD-1:0]      ext_q, ext_d;
  logic [N_MOD-1:0][1:0] st;
  logic                  ctl_en;
  logic                  wdata_unused;

  assign st           = stat_flat;
  assign next_flat    = nxt_q;
  assign wdata_unused = ^wdata;

  // start command only accepted while idle
  assign go_fire = wr_en && (addr == ADR_CMD) && wdata[0] && !busy;

  always_comb begin
    nxt_d  = nxt_q;
    ext_d  = ext_q;
    ctl_en = 1'b0;
    for (int i = 0; i < N_MOD; i++) begin
      if (wr_en && (addr == ADR_CTRL + AW'(i))) begin
        ctl_en = 1'b1;
        if (wdata[1:0] != ST_RSV) nxt_d[i] = wdata[1:0];
        ext_d[i] = EXTRA_MASK[i] & wdata[EXTRA_BIT];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nxt_q <= '0;
      ext_q <= '0;
    end else if (ctl_en) begin
      nxt_q <= nxt_d;
      ext_q <= ext_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADR_BUSY) rdata[0] = busy;
    for (int i = 0; i < N_MOD; i++) begin
      if (addr == ADR_CTRL + AW'(i)) begin
        rdata[1:0]       = nxt_q[i];
        rdata[EXTRA_BIT] = ext_q[i];
      end
      if (addr == ADR_STAT + AW'(i)) rdata[1:0] = st[i];
    end
  end
endmodule

// File: rtl/modctl_seq.sv
module modctl_seq
  import modctl_pkg::*;
#(
  parameter int N_MOD       = 6,
  parameter int AON_CNT     = 4,
  parameter int STEP_CYCLES = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go_fire,
  input  logic [2*N_MOD-1:0] next_flat,
  output logic               busy,
  output logic [2*N_MOD-1:0] stat_flat
);
  localparam int IW = (N_MOD > 1) ? $clog2(N_MOD) : 1;
  localparam int CW = $clog2(STEP_CYCLES + 1);

  logic [N_MOD-1:0][1:0] nx;
  logic [N_MOD-1:0][1:0] stat_q, stat_d, tgt_q, tgt_d;
  logic [N_MOD-1:0]      pend_q, pend_d;
  logic [CW-1:0]         cnt_q, cnt_d;
  logic                  busy_q, busy_d;
  logic [IW-1:0]         cur;
  logic                  upd_en;

  assign nx        = next_flat;
  assign busy      = busy_q;
  assign stat_flat = stat_q;
  assign upd_en    = busy_q | go_fire;

  always_comb begin
    busy_d = busy_q;
    pend_d = pend_q;
    tgt_d  = tgt_q;
    stat_d = stat_q;
    cnt_d  = cnt_q;
    cur    = '0;
    for (int i = N_MOD - 1; i >= 0; i--) begin
      if (pend_q[i]) cur = IW'(i);
    end
    if (!busy_q) begin
      if (go_fire) begin
        busy_d = 1'b1;
        tgt_d  = nx;
        cnt_d  = '0;
        for (int i = 0; i < N_MOD; i++) begin
          pend_d[i] = (i < AON_CNT) && (nx[i] != stat_q[i]);
        end
      end
    end else if (pend_q == '0) begin
      busy_d = 1'b0;
    end else if (cnt_q == CW'(STEP_CYCLES - 1)) begin
      stat_d[cur] = tgt_q[cur];
      pend_d[cur] = 1'b0;
      cnt_d       = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pend_q <= '0;
      tgt_q  <= '0;
      stat_q <= '0;
      cnt_q  <= '0;
    end else if (upd_en) begin
      busy_q <= busy_d;
      pend_q <= pend_d;
      tgt_q  <= tgt_d;
      stat_q <= stat_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/modctl_outs.sv
module modctl_outs
  import modctl_pkg::*;
#(
  parameter int N_MOD = 6
) (
  input  logic [2*N_MOD-1:0] stat_flat,
  output logic [N_MOD-1:0]   mod_clk_en,
  output logic [N_MOD-1:0]   mod_rst_n
);
  for (genvar i = 0; i < N_MOD; i++) begin : g_mod
    logic [1:0] s;
    assign s             = stat_flat[2*i +: 2];
    assign mod_clk_en[i] = (s == ST_SRST) || (s == ST_ON);
    assign mod_rst_n[i]  = (s == ST_ON);
  end
endmodule

// File: rtl/modctl.sv
module modctl
  import modctl_pkg::*;
#(
  parameter int N_MOD       = 6,
  parameter int AON_CNT     = 4,
  parameter int STEP_CYCLES = 3,
  parameter int DW          = 32,
  parameter logic [N_MOD-1:0] EXTRA_MASK = 6'b000101
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic [N_MOD-1:0] mod_clk_en,
  output logic [N_MOD-1:0] mod_rst_n
);
  logic [2*N_MOD-1:0] next_flat;
  logic [2*N_MOD-1:0] stat_flat;
  logic               go_fire;
  logic               busy;

  modctl_regs #(.N_MOD(N_MOD), .DW(DW), .EXTRA_MASK(EXTRA_MASK)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .busy(busy), .stat_flat(stat_flat), .next_flat(next_flat),
    .go_fire(go_fire), .rdata(rdata)
  );

  modctl_seq #(.N_MOD(N_MOD), .AON_CNT(AON_CNT), .STEP_CYCLES(STEP_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .go_fire(go_fire), .next_flat(next_flat),
    .busy(busy), .stat_flat(stat_flat)
  );

  modctl_outs #(.N_MOD(N_MOD)) u_outs (
    .stat_flat(stat_flat), .mod_clk_en(mod_clk_en), .mod_rst_n(mod_rst_n)
  );
endmodule

// File: rtl/modctl_chk.sv
module modctl_chk #(
  parameter int N_MOD   = 6,
  parameter int AON_CNT = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               go_fire,
  input logic               busy,
  input logic [2*N_MOD-1:0] stat_flat,
  input logic [N_MOD-1:0]   mod_clk_en,
  input logic [N_MOD-1:0]   mod_rst_n
);
  logic [2*N_MOD-1:0] prev_stat;
  logic [N_MOD-1:0]   chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_stat <= '0;
    else        prev_stat <= stat_flat;
  end

  for (genvar i = 0; i < N_MOD; i++) begin : g_chg
    assign chg[i] = stat_flat[2*i +: 2] != prev_stat[2*i +: 2];
  end

  // R3: an accepted start command makes the controller busy
  p_busy_after_go_r3: assert property (@(posedge clk) disable iff (!rst_n)
    go_fire |=> busy);

  // R2: status only moves as part of a transition
  p_status_needs_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stat_flat) |-> $past(busy));

  // R4: modules land one at a time
  p_one_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chg));

  for (genvar i = 0; i < N_MOD; i++) begin : g_mod
    // R11: a released reset always comes with a running clock
    p_rst_needs_clk_r11: assert property (@(posedge clk) disable iff (!rst_n)
      mod_rst_n[i] |-> mod_clk_en[i]);
    // R12: the reserved code never appears as a status
    p_no_rsv_state_r12: assert property (@(posedge clk) disable iff (!rst_n)
      stat_flat[2*i +: 2] != 2'd2);
    if (i >= AON_CNT) begin : g_upper
      // R10: the separately powered group stays disabled
      p_upper_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stat_flat[2*i +: 2] == 2'd0);
    end
  end
endmodule

bind modctl modctl_chk #(.N_MOD(N_MOD), .AON_CNT(AON_CNT)) u_chk (
  .clk(clk), .rst_n(rst_n), .go_fire(go_fire), .busy(busy),
  .stat_flat(stat_flat), .mod_clk_en(mod_clk_en), .mod_rst_n(mod_rst_n)
);

// File: tb/modctl_tb.sv
`timescale 1ns/1ps
module modctl_tb;
  localparam int N  = 6;
  localparam int AON = 4;
  localparam int S  = 3;
  localparam logic [N-1:0] XM = 6'b000101;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [N-1:0] mod_clk_en, mod_rst_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int m_stat [N];
  int m_next [N];

  always #2.5 clk = ~clk;

  modctl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .mod_clk_en(mod_clk_en), .mod_rst_n(mod_rst_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_now(input logic [7:0] a, output int v);
    addr = a;
    #1;
    v = int'(rdata);
  endtask

  task automatic wr_ctrl(input int i, input int v);
    wr(8'h10 + 8'(i), 32'(v));
    if (v != 2) m_next[i] = v;
  endtask

  function automatic int exp_clk();
    int r = 0;
    for (int i = 0; i < N; i++) if (m_stat[i] == 1 || m_stat[i] == 3) r |= (1 << i);
    return r;
  endfunction

  function automatic int exp_rst();
    int r = 0;
    for (int i = 0; i < N; i++) if (m_stat[i] == 3) r |= (1 << i);
    return r;
  endfunction

  function automatic int count_k();
    int k = 0;
    for (int i = 0; i < AON; i++) if (m_next[i] != m_stat[i]) k++;
    return k;
  endfunction

  task automatic check_all(input string req);
    int v;
    for (int i = 0; i < N; i++) begin
      rd_now(8'h20 + 8'(i), v);
      chk((v & 3) == m_stat[i], req, v & 3, m_stat[i]);
    end
    chk(int'(mod_clk_en) == exp_clk(), {req, " R11 clk_en"}, int'(mod_clk_en), exp_clk());
    chk(int'(mod_rst_n) == exp_rst(), {req, " R11 rst_n"}, int'(mod_rst_n), exp_rst());
  endtask

  // counts busy cycles starting from the current negedge
  task automatic count_busy(output int n);
    int v;
    n = 0;
    rd_now(8'h01, v);
    while ((v & 1) && n < 1000) begin
      n++;
      @(negedge clk);
      rd_now(8'h01, v);
    end
  endtask

  task automatic apply_model();
    for (int i = 0; i < AON; i++) m_stat[i] = m_next[i];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R3 watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int v, n, k;
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    for (int i = 0; i < N; i++) begin m_stat[i] = 0; m_next[i] = 0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_all("R1 status");
    for (int i = 0; i < N; i++) begin
      rd_now(8'h10 + 8'(i), v);
      chk(v == 0, "R1 ctrl", v, 0);
    end
    rd_now(8'h01, v);
    chk(v == 0, "R1 busy", v, 0);

    // R3 command write with bit 0 clear starts nothing
    wr(8'h00, 32'h2);
    rd_now(8'h01, v);
    chk(v == 0, "R3 no-go busy", v, 0);

    // R6 empty transition: one busy cycle
    wr(8'h00, 32'h1);
    count_busy(n);
    chk(n == 1, "R6 empty busy", n, 1);

    // R4 ordering: modules 1 and 3 to enabled
    wr_ctrl(1, 3); wr_ctrl(3, 3);
    check_all("R2 staged");
    wr(8'h00, 32'h1);
    @(negedge clk); @(negedge clk);
    rd_now(8'h21, v); chk(v == 0, "R4 m1 before step", v, 0);
    @(negedge clk);
    rd_now(8'h21, v); chk(v == 3, "R4 m1 at step", v, 3);
    rd_now(8'h23, v); chk(v == 0, "R4 m3 waits", v, 0);
    @(negedge clk); @(negedge clk);
    rd_now(8'h23, v); chk(v == 0, "R4 m3 before step", v, 0);
    @(negedge clk);
    rd_now(8'h23, v); chk(v == 3, "R4 m3 at step", v, 3);
    rd_now(8'h01, v); chk(v == 1, "R3 busy at last step", v, 1);
    @(negedge clk);
    rd_now(8'h01, v); chk(v == 0, "R3 busy end", v, 0);
    apply_model();
    check_all("R5 after order");

    // R7/R8: GO and control write during busy
    wr_ctrl(0, 3); wr_ctrl(2, 1);
    wr(8'h00, 32'h1);               // t=0, k=2
    wr(8'h00, 32'h1);               // t=2, ignored
    wr(8'h10, 32'h1);               // t=4, stage m0 -> 1
    count_busy(n);
    chk(n == 3, "R7 remaining busy", n, 3);
    apply_model();
    m_next[0] = 1;
    check_all("R8 captured targets");
    rd_now(8'h10, v);
    chk((v & 3) == 1, "R8 staged ctrl", v & 3, 1);
    repeat (3) @(negedge clk);
    rd_now(8'h01, v);
    chk(v == 0, "R7 no restart", v, 0);
    wr(8'h00, 32'h1);
    count_busy(n);
    chk(n == S + 1, "R8 later go", n, S + 1);
    apply_model();
    check_all("R8 applied");

    // R12 reserved code rejected
    wr(8'h11, 32'h2);
    rd_now(8'h11, v);
    chk((v & 3) == m_next[1], "R12 reject", v & 3, m_next[1]);

    // R9 extra flag
    for (int i = 0; i < N; i++) begin
      wr(8'h10 + 8'(i), 32'h200 | 32'(m_next[i]));
      rd_now(8'h10 + 8'(i), v);
      chk(((v >> 9) & 1) == int'(XM[i]), "R9 extra bit", (v >> 9) & 1, int'(XM[i]));
      chk((v & 3) == m_next[i], "R9 next kept", v & 3, m_next[i]);
    end

    // sweep all legal request combinations for always-on modules
    for (int c = 0; c < 81; c++) begin
      int code;
      int dv = c;
      for (int j = 0; j < AON; j++) begin
        code = dv % 3; dv = dv / 3;
        wr_ctrl(j, (code == 2) ? 3 : code);
      end
      wr_ctrl(4, (c % 2) ? 3 : 1);
      wr_ctrl(5, 3);
      check_all("R2 staged sweep");
      k = count_k();
      wr(8'h00, 32'h1);
      count_busy(n);
      chk(n == k * S + 1, (k == 0) ? "R6 sweep busy" : "R3 sweep busy", n, k * S + 1);
      apply_model();
      check_all("R5 R10 sweep status");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule